// File: doc/BRIEF.md
# Chained Logic Element with Two-Bit Carry-Skip Adder

This block models a row of programmable logic elements. Each element holds a six-input lookup table that splits into four four-input tables, and a hard two-bit adder. All four tables read the same low four element inputs. In logic mode an element drives its results straight from the tables. In arithmetic mode the four table outputs become the adder's two operand bit pairs. The adder resolves its two bits with a carry-skip path. Its carry-out runs on a dedicated wire into the next element.

Software loads each element's 64-bit table word and its mode through a synchronous write port. Once `N` elements are all set to arithmetic mode with pass-through tables, the row adds two `2N`-bit unsigned operands plus a carry-in. The last carry becomes the overflow flag. The data path from the element inputs to the results is purely combinational.

Top module: `le_chain`

## Requirements
- R1: After reset every element is in logic mode and every table holds zero, so `res` and `carry_out` read 0 for any input.
- R2: A clock edge with `cfg_we` high loads `cfg_tables` and `cfg_arith` into the element selected by `cfg_sel`. The new contents act from that edge on, and the other elements keep their contents.
- R3: Table k of an element sits in bits 16k+15..16k of its word. Its output is the bit at index x[3:0] of that 16-bit word, where x is the element's six-bit slice of `lut_x`.
- R4: In logic mode, `res[2e]` of element e is the output of table number x[5:4] (the six-input function). `res[2e+1]` is the output of table 0.
- R5: In arithmetic mode, the adder's operands are taken from the tables: low bit pair (table 0, table 1), high bit pair (table 2, table 3). The words 16'hAAAA, 16'hCCCC, 16'hF0F0 and 16'hFF00 pass x[0], x[1], x[2] and x[3] through unchanged.
- R6: Each arithmetic element forms its two result bits and its carry-out as the two-bit sum of its operand pairs plus its carry-in. The low sum bit is the XOR of the low operand bits and the carry-in.
- R7: When both bit positions propagate (each operand pair differs), the carry-in goes straight to the carry-out. Otherwise the carry-out is the ripple carry through the two bits.
- R8: Element 0 takes `cin`, and each later element takes its lower neighbour's carry-out. With all elements in arithmetic mode and pass-through tables, `{carry_out,res}` equals A+B+cin. Bit 2e of A sits at x[0] and bit 2e+1 at x[2]; B uses x[1] and x[3].
- R9: In arithmetic mode, inputs x[5:4] of an element have no effect on any output.
- R10: An element in logic mode drives a carry-out of 0, so its upper neighbour sees carry-in 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration storage |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SELW | Index of the element to configure |
| cfg_tables | input | 64 | Four 16-bit table words, table 0 in the low bits |
| cfg_arith | input | 1 | Mode to load: 1 arithmetic, 0 logic |
| lut_x | input | 6N | Six inputs per element, element e at bits 6e+5..6e |
| cin | input | 1 | Carry into element 0 |
| res | output | 2N | Two result bits per element |
| carry_out | output | 1 | Carry from the last element (unsigned overflow) |

## Verification
A configuration write acts one clock edge after it is driven. The bench drives writes on the falling edge. It samples once before the next rising edge, where the old contents must still show, and again after that edge, where the new contents must show. Results from `lut_x` and `cin` carry no register, so they are due in the same cycle. The bench changes the operands, waits one time unit for the combinational path to settle, and compares them with its own sum or table model. The clocked properties sample these settled values at the rising edge.

// File: rtl/le2_pkg.sv
package le2_pkg;
  localparam int TBL_BITS = 16;
  localparam int TBLS     = 4;
  localparam int XW       = 6;
  localparam int CFGW     = TBLS * TBL_BITS;

  // read one 16-entry table at a 4-bit address
  function automatic logic lut4_read(input logic [TBL_BITS-1:0] word,
                                     input logic [3:0] addr);
    return word[addr];
  endfunction

  // carry of one full-adder position given generate/propagate
  function automatic logic gp_carry(input logic g, input logic p, input logic c);
    return g | (p & c);
  endfunction
endpackage

// File: rtl/le_frac_lut.sv
module le_frac_lut
  import le2_pkg::*;
(
  input  logic [CFGW-1:0] cfg,
  input  logic [XW-1:0]   x,
  output logic [TBLS-1:0] tout,
  output logic            f6
);
  for (genvar k = 0; k < TBLS; k++) begin : g_tbl
    assign tout[k] = lut4_read(cfg[k*TBL_BITS +: TBL_BITS], x[3:0]);
  end
  assign f6 = tout[x[5:4]];
endmodule

// File: rtl/le_skip_add2.sv
module le_skip_add2
  import le2_pkg::*;
(
  input  logic [1:0] a,
  input  logic [1:0] b,
  input  logic       ci,
  output logic [1:0] s,
  output logic       co,
  output logic       skip
);
  logic [1:0] p, g;
  logic       c_mid, c_rip;

  assign p     = a ^ b;
  assign g     = a & b;
  assign c_mid = gp_carry(g[0], p[0], ci);
  assign c_rip = gp_carry(g[1], p[1], c_mid);
  assign skip  = &p;
  assign co    = skip ? ci : c_rip;
  assign s     = p ^ {c_mid, ci};
endmodule

// File: rtl/le_cell.sv
module le_cell
  import le2_pkg::*;
(
  input  logic [CFGW-1:0] cfg,
  input  logic            arith,
  input  logic [XW-1:0]   x,
  input  logic            ci,
  output logic [1:0]      r,
  output logic            co,
  output logic            skip,
  output logic [1:0]      op_a,
  output logic [1:0]      op_b
);
  logic [TBLS-1:0] tout;
  logic            f6;
  logic [1:0]      s;
  logic            co_add;

  le_frac_lut u_lut (.cfg(cfg), .x(x), .tout(tout), .f6(f6));

  assign op_a = {tout[2], tout[0]};
  assign op_b = {tout[3], tout[1]};

  le_skip_add2 u_add (.a(op_a), .b(op_b), .ci(ci), .s(s), .co(co_add), .skip(skip));

  assign r  = arith ? s : {tout[0], f6};
  assign co = arith & co_add;
endmodule

// File: rtl/le_chain.sv
module le_chain
  import le2_pkg::*;
#(
  parameter int N    = 4,
  parameter int W    = 2 * N,
  parameter int SELW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SELW-1:0]   cfg_sel,
  input  logic [CFGW-1:0]   cfg_tables,
  input  logic              cfg_arith,
  input  logic [XW*N-1:0]   lut_x,
  input  logic              cin,
  output logic [W-1:0]      res,
  output logic              carry_out
);
  logic [CFGW-1:0] cfg_q [N];
  logic [N-1:0]    arith_vec;
  logic [N:0]      chain;
  logic [N-1:0]    skip_vec;
  logic [W-1:0]    adda_vec, addb_vec;
  logic [N-1:0]    cin_vec, cout_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < N; e++) cfg_q[e] <= '0;
      arith_vec <= '0;
    end else if (cfg_we) begin
      for (int e = 0; e < N; e++) begin
        if (cfg_sel == SELW'(e)) begin
          cfg_q[e]     <= cfg_tables;
          arith_vec[e] <= cfg_arith;
        end
      end
    end
  end

  assign chain[0] = cin;

  for (genvar e = 0; e < N; e++) begin : g_el
    le_cell u_cell (
      .cfg  (cfg_q[e]),
      .arith(arith_vec[e]),
      .x    (lut_x[e*XW +: XW]),
      .ci   (chain[e]),
      .r    (res[2*e +: 2]),
      .co   (chain[e+1]),
      .skip (skip_vec[e]),
      .op_a (adda_vec[2*e +: 2]),
      .op_b (addb_vec[2*e +: 2])
    );
  end

  assign cin_vec   = chain[N-1:0];
  assign cout_vec  = chain[N:1];
  assign carry_out = chain[N];
endmodule

// File: rtl/le_chain_chk.sv
module le_chain_chk #(
  parameter int N    = 4,
  parameter int W    = 2 * N,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic            cfg_arith,
  input  logic [N-1:0]    arith_vec,
  input  logic [N-1:0]    skip_vec,
  input  logic [N-1:0]    cin_vec,
  input  logic [N-1:0]    cout_vec,
  input  logic [W-1:0]    adda_vec,
  input  logic [W-1:0]    addb_vec,
  input  logic [W-1:0]    res
);
  for (genvar e = 0; e < N; e++) begin : g_chk
    AST_SKIP_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (arith_vec[e] && skip_vec[e]) |-> (cout_vec[e] == cin_vec[e])); // R7
    AST_HIGH_GENERATE: assert property (@(posedge clk) disable iff (!rst_n)
      (arith_vec[e] && adda_vec[2*e+1] && addb_vec[2*e+1]) |-> cout_vec[e]); // R7
    AST_LOW_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      arith_vec[e] |-> (res[2*e] == (adda_vec[2*e] ^ addb_vec[2*e] ^ cin_vec[e]))); // R6
    AST_IDLE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      !arith_vec[e] |-> !cout_vec[e]); // R10
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == SELW'(e)) |=> (arith_vec[e] == $past(cfg_arith))); // R2
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_sel == SELW'(e)) |=> $stable(arith_vec[e])); // R2
  end
endmodule

bind le_chain le_chain_chk #(.N(N), .W(W), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_arith(cfg_arith), .arith_vec(arith_vec), .skip_vec(skip_vec),
  .cin_vec(cin_vec), .cout_vec(cout_vec), .adda_vec(adda_vec),
  .addb_vec(addb_vec), .res(res)
);

// File: tb/le_chain_test.sv
module le_chain_test;
  localparam int N  = 4;
  localparam int W  = 2 * N;
  localparam int XT = 6 * N;
  localparam logic [63:0] PASS = {16'hFF00, 16'hF0F0, 16'hCCCC, 16'hAAAA};

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cfg_we = 0;
  logic [1:0]    cfg_sel = '0;
  logic [63:0]   cfg_tables = '0;
  logic          cfg_arith = 0;
  logic [XT-1:0] lut_x = '0;
  logic          cin = 0;
  logic [W-1:0]  res;
  logic          carry_out;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [63:0] m_tbl [N];
  logic [N-1:0] m_arith = '0;

  le_chain #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_tables(cfg_tables), .cfg_arith(cfg_arith), .lut_x(lut_x),
    .cin(cin), .res(res), .carry_out(carry_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // operands into element inputs; hi supplies x[5:4] of every element
  function automatic logic [XT-1:0] pack(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [2*N-1:0] hi);
    logic [XT-1:0] x;
    for (int e = 0; e < N; e++)
      x[6*e +: 6] = {hi[2*e +: 2], b[2*e+1], a[2*e+1], b[2*e], a[2*e]};
    return x;
  endfunction

  function automatic logic [W:0] model(input logic [XT-1:0] x, input logic ci);
    logic [W-1:0] r;
    logic         c;
    c = ci;
    for (int e = 0; e < N; e++) begin
      logic [5:0] xe;
      logic [3:0] t;
      logic [2:0] v;
      xe = x[6*e +: 6];
      for (int k = 0; k < 4; k++) t[k] = m_tbl[e][16*k + int'(xe[3:0])];
      if (m_arith[e]) begin
        v = 3'({t[2], t[0]}) + 3'({t[3], t[1]}) + 3'(c);
        r[2*e +: 2] = v[1:0];
        c = v[2];
      end else begin
        r[2*e]   = t[xe[5:4]];
        r[2*e+1] = t[0];
        c = 1'b0;
      end
    end
    return {c, r};
  endfunction

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int e, input logic [63:0] tb, input logic ar);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(e); cfg_tables = tb; cfg_arith = ar;
    @(negedge clk);
    cfg_we = 0;
    m_tbl[e] = tb; m_arith[e] = ar;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int e = 0; e < N; e++) m_tbl[e] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    lut_x = XT'($urandom()); cin = 1; #1;
    check("R1", {carry_out, res}, '0);

    // R3 R4: logic mode with random table contents
    for (int e = 0; e < N; e++) write_cfg(e, {$urandom(), $urandom()}, 1'b0);
    for (int i = 0; i < 300; i++) begin
      lut_x = XT'($urandom()); cin = 1'($urandom()); #1;
      check("R4", {carry_out, res}, model(lut_x, cin));
    end

    // R5 R8: pass-through tables, exhaustive 8-bit against plain sum
    for (int e = 0; e < N; e++) write_cfg(e, PASS, 1'b1);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++) begin
          lut_x = pack(W'(a), W'(b), '0); cin = 1'(c); #1;
          check("R8", {carry_out, res}, 9'(a + b + c));
          #1;
        end

    // R7: every position propagates, carry goes straight through
    lut_x = pack(8'h55, 8'hAA, '0); cin = 1; #1;
    check("R7", {carry_out, res}, 9'h100);
    cin = 0; #1;
    check("R7", {carry_out, res}, 9'h0FF);
    // R6: full ripple
    lut_x = pack(8'hFF, 8'h01, '0); cin = 0; #1;
    check("R6", {carry_out, res}, 9'h100);

    // R9: upper inputs ignored in arithmetic mode
    for (int i = 0; i < 100; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom()); b = 8'($urandom()); cin = 1'($urandom());
      lut_x = pack(a, b, 8'($urandom())); #1;
      check("R9", {carry_out, res}, 9'(a) + 9'(b) + 9'(cin));
    end

    // R2: write takes effect at the edge, not before
    lut_x = pack(8'h0F, 8'h01, '0); cin = 0; #1;
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'd1; cfg_tables = 64'hFFFF_0000_1234_5678; cfg_arith = 0;
    #1;
    check("R2", {carry_out, res}, 9'h010);
    @(negedge clk);
    cfg_we = 0;
    m_tbl[1] = 64'hFFFF_0000_1234_5678; m_arith[1] = 0;
    #1;
    check("R2", {carry_out, res}, model(lut_x, cin));

    // R10: logic element in the middle of a chain cuts the carry
    for (int i = 0; i < 100; i++) begin
      lut_x = XT'($urandom()); cin = 1'($urandom()); #1;
      check("R10", {carry_out, res}, model(lut_x, cin));
    end
    lut_x = pack(8'hFF, 8'hFF, '0); cin = 1; #1;
    check("R10", {carry_out, res}, model(lut_x, cin));

    // R5: arithmetic fed by non-pass-through tables
    for (int e = 0; e < N; e++) write_cfg(e, {$urandom(), $urandom()}, 1'b1);
    for (int i = 0; i < 200; i++) begin
      lut_x = XT'($urandom()); cin = 1'($urandom()); #1;
      check("R5", {carry_out, res}, model(lut_x, cin));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule